// File: doc/BRIEF.md
# Serial Configuration Frame Checker

This block sits behind a one-bit configuration input and checks the framing of a serial load image as it arrives. Each clock cycle on which the bit strobe is high delivers one bit. The checker first discards a fixed-length lead-in of arbitrary bits. It then expects a fixed number of frames. Each frame is a single low start bit, a wide data field sent most significant bit first, and a group of high stop bits. The stop bits of one frame are followed directly by the start bit of the next frame.

Each frame that passes its framing check is placed on a parallel data output, together with its index and a one-cycle valid pulse, so that downstream logic can write it into storage. After the last frame the checker needs a minimum run of high trailer bits before it declares the load complete. Any framing violation stops parsing. The block then holds an error flag and the number of the offending frame until it is reset.

Top module: `cfg_frame_checker`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `frame_err` and `frame_valid` are all low.
- R2: The first PRE_LEN strobed bits are discarded whatever their values, including 0. The start bit of frame 0 is the bit at strobed position PRE_LEN.
- R3: A start-bit position that carries 1 is a framing error. `frame_err` rises and `err_index` holds the number of the frame being parsed.
- R4: The DATA_W data bits of a frame are assembled MSB first, with the first data bit received ending up in `frame_data[DATA_W-1]`. The cycle after the last stop bit is accepted, `frame_valid` is high for exactly one cycle, with the field on `frame_data` and the frame number (0 to FRAMES-1) on `frame_index`.
- R5: A 0 in any of the STOP_W stop-bit positions is a framing error, and `err_index` holds that frame's number.
- R6: Cycles with `bit_valid` low leave the parser unchanged, whatever the value on `bit_in`.
- R7: After frame FRAMES-1, `done` rises the cycle after the POST_MIN-th consecutive high trailer bit is accepted, and not before. It then stays high, and later bits of any value are ignored.
- R8: A 0 among the first POST_MIN trailer bits is a framing error with `err_index` equal to FRAMES.
- R9: After a framing error, `frame_err` stays high until reset. No further `frame_valid` pulse occurs and `done` never rises.
- R10: The start bit of frame n+1 immediately follows the last stop bit of frame n, with no idle bits between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial configuration bit |
| frame_valid | output | 1 | One-cycle pulse: a checked frame is on `frame_data` |
| frame_data | output | DATA_W | Data field of the last checked frame, MSB first as received |
| frame_index | output | $clog2(FRAMES+1) | Number of the frame on `frame_data` |
| done | output | 1 | Whole image and trailer received without error (sticky) |
| frame_err | output | 1 | Framing violation seen (sticky until reset) |
| err_index | output | $clog2(FRAMES+1) | Frame number at the violation, FRAMES for the trailer |

## Verification
If the bit counter or the phase register drifts by even one position, a data byte is shifted on `frame_data` or a data bit lands on a start or stop slot. The first case appears as a wrong word at the next `frame_valid`. The second appears as `frame_err` within one frame length. A frame counter that is off shows up at once as a wrong `frame_index` or `err_index`, or as `done` rising a frame early or late. A strobe that is ignored shows up as a spurious error or a corrupted word during the first idle gap.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;

  typedef enum logic [2:0] {
    PH_LEAD  = 3'd0,
    PH_START = 3'd1,
    PH_FIELD = 3'd2,
    PH_STOP  = 3'd3,
    PH_TAIL  = 3'd4,
    PH_OK    = 3'd5,
    PH_FAIL  = 3'd6
  } phase_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/cfgchk_count.sv
module cfgchk_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i || inc_i) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/cfgchk_shift.sv
module cfgchk_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  generate
    if (W == 1) begin : g_single
      assign word_d = bit_i;
    end else begin : g_multi
      assign word_d = {word_q[W-2:0], bit_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (en_i) word_q <= word_d;
  end

  assign word_o = word_q;

endmodule

// File: rtl/cfgchk_ctrl.sv
module cfgchk_ctrl
  import cfgchk_pkg::*;
#(
  parameter int PRE_LEN  = 40,
  parameter int DATA_W   = 71,
  parameter int STOP_W   = 3,
  parameter int FRAMES   = 197,
  parameter int POST_MIN = 4,
  parameter int CNT_W    = 7,
  parameter int FR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] bit_cnt_i,
  input  logic [FR_W-1:0]  frm_cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             shift_en_o,
  output logic             frame_end_o,
  output logic             err_set_o,
  output logic             done_set_o
);

  localparam logic [CNT_W-1:0] LEAD_LAST  = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] FIELD_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] STOP_LAST  = CNT_W'(STOP_W - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(POST_MIN - 1);
  localparam logic [FR_W-1:0]  FRM_LAST   = FR_W'(FRAMES - 1);

  phase_e ph_q;
  phase_e ph_d;

  always_comb begin
    ph_d        = ph_q;
    cnt_clr_o   = 1'b0;
    cnt_inc_o   = 1'b0;
    shift_en_o  = 1'b0;
    frame_end_o = 1'b0;
    err_set_o   = 1'b0;
    done_set_o  = 1'b0;
    if (bit_valid_i) begin
      unique case (ph_q)
        PH_LEAD: begin
          if (bit_cnt_i == LEAD_LAST) begin
            ph_d      = PH_START;
            cnt_clr_o = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        PH_START: begin
          if (!bit_i) begin
            ph_d      = PH_FIELD;
            cnt_clr_o = 1'b1;
          end else begin
            ph_d      = PH_FAIL;
            err_set_o = 1'b1;
          end
        end
        PH_FIELD: begin
          shift_en_o = 1'b1;
          if (bit_cnt_i == FIELD_LAST) begin
            ph_d      = PH_STOP;
            cnt_clr_o = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        PH_STOP: begin
          if (!bit_i) begin
            ph_d      = PH_FAIL;
            err_set_o = 1'b1;
          end else if (bit_cnt_i == STOP_LAST) begin
            cnt_clr_o   = 1'b1;
            frame_end_o = 1'b1;
            ph_d        = (frm_cnt_i == FRM_LAST) ? PH_TAIL : PH_START;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        PH_TAIL: begin
          if (!bit_i) begin
            ph_d      = PH_FAIL;
            err_set_o = 1'b1;
          end else if (bit_cnt_i == TAIL_LAST) begin
            ph_d       = PH_OK;
            cnt_clr_o  = 1'b1;
            done_set_o = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        default: ph_d = ph_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ph_q <= PH_LEAD;
    else if (bit_valid_i) ph_q <= ph_d;
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid_i |=> $stable(ph_q)); // R6
  AST_FAIL_ABSORBS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_FAIL) |=> (ph_q == PH_FAIL)); // R9
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({frame_end_o, err_set_o, done_set_o}) <= 1); // R9

endmodule

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker
  import cfgchk_pkg::*;
#(
  parameter int PRE_LEN  = 40,
  parameter int DATA_W   = 71,
  parameter int STOP_W   = 3,
  parameter int FRAMES   = 197,
  parameter int POST_MIN = 4,
  localparam int FR_W    = $clog2(FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              frame_valid,
  output logic [DATA_W-1:0] frame_data,
  output logic [FR_W-1:0]   frame_index,
  output logic              done,
  output logic              frame_err,
  output logic [FR_W-1:0]   err_index
);

  localparam int LONGEST = max_of4(PRE_LEN, DATA_W, STOP_W, POST_MIN);
  localparam int CNT_W   = $clog2(LONGEST + 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [FR_W-1:0]   frm_cnt;
  logic [DATA_W-1:0] field_word;
  logic              cnt_clr;
  logic              cnt_inc;
  logic              shift_en;
  logic              frame_end;
  logic              err_set;
  logic              done_set;

  cfgchk_count #(.W(CNT_W)) u_bitcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (bit_cnt)
  );

  cfgchk_count #(.W(FR_W)) u_frmcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (1'b0),
    .inc_i (frame_end),
    .cnt_o (frm_cnt)
  );

  cfgchk_shift #(.W(DATA_W)) u_field (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (shift_en),
    .bit_i  (bit_in),
    .word_o (field_word)
  );

  cfgchk_ctrl #(
    .PRE_LEN  (PRE_LEN),
    .DATA_W   (DATA_W),
    .STOP_W   (STOP_W),
    .FRAMES   (FRAMES),
    .POST_MIN (POST_MIN),
    .CNT_W    (CNT_W),
    .FR_W     (FR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid_i (bit_valid),
    .bit_i       (bit_in),
    .bit_cnt_i   (bit_cnt),
    .frm_cnt_i   (frm_cnt),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .shift_en_o  (shift_en),
    .frame_end_o (frame_end),
    .err_set_o   (err_set),
    .done_set_o  (done_set)
  );

  logic              fv_q;
  logic [DATA_W-1:0] fd_q;
  logic [FR_W-1:0]   fi_q;
  logic              done_q;
  logic              err_q;
  logic [FR_W-1:0]   ei_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fv_q <= 1'b0;
    else        fv_q <= frame_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_q <= '0;
      fi_q <= '0;
    end else if (frame_end) begin
      fd_q <= field_word;
      fi_q <= frm_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (done_set) done_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ei_q  <= '0;
    end else if (err_set) begin
      err_q <= 1'b1;
      ei_q  <= frm_cnt;
    end
  end

  assign frame_valid = fv_q;
  assign frame_data  = fd_q;
  assign frame_index = fi_q;
  assign done        = done_q;
  assign frame_err   = err_q;
  assign err_index   = ei_q;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fv_q |=> !fv_q); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fv_q |-> (fi_q < FR_W'(FRAMES))); // R4
  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !fv_q); // R9
  AST_ERR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (ei_q <= FR_W'(FRAMES))); // R8

endmodule

// File: tb/cfg_frame_checker_test.sv
module cfg_frame_checker_test;

  localparam int PRE_LEN  = 6;
  localparam int DATA_W   = 8;
  localparam int STOP_W   = 3;
  localparam int FRAMES   = 4;
  localparam int POST_MIN = 4;
  localparam int FR_W     = $clog2(FRAMES + 1);

  typedef struct packed {
    logic [DATA_W-1:0] word;
    logic [FR_W-1:0]   idx;
  } vec_t;

  localparam vec_t VEC [FRAMES] = '{
    '{word: 8'hA5, idx: 3'd0},
    '{word: 8'h3C, idx: 3'd1},
    '{word: 8'hFF, idx: 3'd2},
    '{word: 8'h01, idx: 3'd3}
  };

  logic              clk;
  logic              rst_n;
  logic              bit_valid;
  logic              bit_in;
  logic              frame_valid;
  logic [DATA_W-1:0] frame_data;
  logic [FR_W-1:0]   frame_index;
  logic              done;
  logic              frame_err;
  logic [FR_W-1:0]   err_index;

  cfg_frame_checker #(
    .PRE_LEN  (PRE_LEN),
    .DATA_W   (DATA_W),
    .STOP_W   (STOP_W),
    .FRAMES   (FRAMES),
    .POST_MIN (POST_MIN)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid   (bit_valid),
    .bit_in      (bit_in),
    .frame_valid (frame_valid),
    .frame_data  (frame_data),
    .frame_index (frame_index),
    .done        (done),
    .frame_err   (frame_err),
    .err_index   (err_index)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int nval   = 0;
  int gap    = 0;
  bit ended  = 1'b0;
  logic [DATA_W-1:0] cap_data [16];
  logic [FR_W-1:0]   cap_idx  [16];

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      if (nval < 16) begin
        cap_data[nval] = frame_data;
        cap_idx[nval]  = frame_index;
      end
      nval = nval + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in    = k[0];
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = b;
    if (gap > 0) idle_gap(gap);
  endtask

  task automatic settle();
    @(negedge clk);
    bit_valid = 1'b0;
    bit_in    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    bit_valid = 1'b0;
    bit_in    = 1'b0;
    nval      = 0;
    gap       = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_lead(input bit alternate);
    for (int k = 0; k < PRE_LEN; k++) send_bit(alternate ? k[0] : 1'b0);
  endtask

  task automatic send_raw(input logic start, input logic [DATA_W-1:0] w, input logic [STOP_W-1:0] stops);
    send_bit(start);
    for (int k = DATA_W - 1; k >= 0; k--) send_bit(w[k]);
    for (int k = STOP_W - 1; k >= 0; k--) send_bit(stops[k]);
  endtask

  task automatic send_frame(input logic [DATA_W-1:0] w);
    send_raw(1'b0, w, '1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended  = 1'b1;
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    bit_valid = 1'b0;
    bit_in    = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !frame_err && !frame_valid, "R1 in reset", {done, frame_err, frame_valid}, 0);
    rst_n = 1'b1;
    settle();
    chk(!done && !frame_err && !frame_valid, "R1 after release", {done, frame_err, frame_valid}, 0);

    // Run A: all-zero lead-in (R2), back-to-back frames (R10), table walk
    send_lead(1'b0);
    for (int i = 0; i < FRAMES; i++) send_frame(VEC[i].word);
    for (int k = 0; k < POST_MIN - 1; k++) send_bit(1'b1);
    settle();
    chk(!done, "R7 done not before last trailer bit", done, 0);
    send_bit(1'b1);
    settle();
    chk(done && !frame_err, "R7 done after trailer", {done, frame_err}, 2'b10);
    chk(nval == FRAMES, "R4 one pulse per frame", nval, FRAMES);
    for (int i = 0; i < FRAMES; i++) begin
      chk(cap_data[i] == VEC[i].word, "R4 R10 R2 frame word", cap_data[i], VEC[i].word);
      chk(cap_idx[i] == VEC[i].idx, "R4 frame index", cap_idx[i], VEC[i].idx);
    end
    send_bit(1'b0);
    send_bit(1'b0);
    send_frame(8'h55);
    settle();
    chk(done && !frame_err && nval == FRAMES, "R7 bits after done ignored", {done, frame_err, nval[7:0]}, {2'b10, 8'(FRAMES)});

    // Run B: strobe gaps with toggling data (R6), alternating lead-in (R2)
    do_reset();
    gap = 2;
    send_lead(1'b1);
    for (int i = 0; i < FRAMES; i++) send_frame(VEC[FRAMES-1-i].word);
    for (int k = 0; k < POST_MIN; k++) send_bit(1'b1);
    gap = 0;
    settle();
    chk(done && !frame_err, "R6 gaps leave parser intact", {done, frame_err}, 2'b10);
    chk(nval == FRAMES && cap_data[0] == VEC[FRAMES-1].word && cap_data[FRAMES-1] == VEC[0].word,
        "R6 words with gaps", {cap_data[0], cap_data[FRAMES-1]}, {VEC[FRAMES-1].word, VEC[0].word});

    // Run C: bad start bit on frame 1 (R3), then stays stopped (R9)
    do_reset();
    send_lead(1'b0);
    send_frame(VEC[0].word);
    send_bit(1'b1);
    settle();
    chk(frame_err && err_index == 1, "R3 start bit error", {frame_err, err_index}, {1'b1, 3'd1});
    send_frame(VEC[1].word);
    send_frame(VEC[2].word);
    send_frame(VEC[3].word);
    for (int k = 0; k < POST_MIN; k++) send_bit(1'b1);
    settle();
    chk(frame_err && !done && nval == 1, "R9 parsing stopped", {frame_err, done, nval[7:0]}, {2'b10, 8'd1});

    // Run D: last stop bit of frame 0 low (R5)
    do_reset();
    send_lead(1'b0);
    send_raw(1'b0, VEC[0].word, 3'b110);
    settle();
    chk(frame_err && err_index == 0 && nval == 0, "R5 last stop bit", {frame_err, err_index, nval[7:0]}, {1'b1, 3'd0, 8'd0});

    // Run D2: first stop bit of frame 2 low (R5)
    do_reset();
    send_lead(1'b0);
    send_frame(VEC[0].word);
    send_frame(VEC[1].word);
    send_raw(1'b0, VEC[2].word, 3'b011);
    settle();
    chk(frame_err && err_index == 2 && nval == 2, "R5 first stop bit", {frame_err, err_index, nval[7:0]}, {1'b1, 3'd2, 8'd2});

    // Run E: zero in trailer (R8)
    do_reset();
    send_lead(1'b0);
    for (int i = 0; i < FRAMES; i++) send_frame(VEC[i].word);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    settle();
    chk(frame_err && err_index == FRAMES && !done, "R8 trailer zero", {frame_err, err_index, done}, {1'b1, 3'(FRAMES), 1'b0});

    // Reset clears sticky state (R1)
    do_reset();
    settle();
    chk(!done && !frame_err && !frame_valid, "R1 reset clears error", {done, frame_err, frame_valid}, 0);

    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule